// File: doc/BRIEF.md
# Programmable Interval Timer with Prescaler

This block is a 16-bit down-counting interval timer that raises a periodic interrupt. Software reaches it through a small register bus made of an address, a write strobe, write data and combinational read data. There are three registers: a control and status word, a modulus word, and a read-only view of the live count. A power-of-two prescaler first halves the system clock and then divides it further, and its pulse steps the counter.

Each time the counter passes zero it sets an interrupt flag and loads its limit again. In reload mode the limit is the modulus; in free-running mode it is 0xFFFF. The interrupt pin is the flag qualified by an interrupt-enable bit. Software clears the flag by writing a 1 to it. An overwrite option lets a modulus write load the counter at once. A control write that only changes the interrupt bits leaves the running count alone. The debug and doze bits are stored and read back, but they have no effect.

The register bus has no handshake. A write takes effect at the clock edge on which `bus_we` is sampled high. Reads return, in the same cycle, the register selected by `bus_addr`.

Top module: `pit_timer`

## Requirements
- R1: After reset the control word reads 0x0000, the modulus reads 0xFFFF, the count reads 0x0000 and `irq` is 0.
- R2: The control word is at offset 0 and has these bits: bit0 run enable, bit1 reload mode, bit2 flag, bit3 interrupt enable, bit4 overwrite, bit5 debug, bit6 doze, bits 11:8 prescale code PRE. Bit 7 and bits 15:12 read 0. A written flag bit is never stored as 1. The modulus is at offset 2 and the count at offset 4. Writes to offset 4 change nothing.
- R3: While enabled, the count decrements once every 2^(PRE+1) clocks. The first decrement falls on the 2^(PRE+1)-th edge after the edge that restarted the count.
- R4: A prescaler tick that finds the count at 0x0000 is an expiry. On that edge the count loads its limit and the flag is set. The limit is the modulus in reload mode and 0xFFFF otherwise.
- R5: `irq` is 1 exactly when the flag and the interrupt-enable bit are both 1.
- R6: A control write with bit2 = 1 clears the flag. A control write with bit2 = 0 leaves the flag unchanged.
- R7: A control write whose bits other than the flag and the interrupt enable equal the stored ones does not disturb the count or the prescaler.
- R8: Any other control write loads the count with the limit of the new configuration on its edge and restarts the prescaler. While the run enable is 0 the count holds.
- R9: A modulus write clears the flag. With overwrite set, the count takes the written value on the same edge, in either mode. With overwrite clear, the count is untouched and the new modulus is only the next reload limit.
- R10: When an expiry and a flag-clearing write fall on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register byte offset (0, 2 or 4) |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Every register write shows its effect from the edge that samples the strobe. The bench therefore drives a write just after one falling edge and samples at the next falling edge. Count values are due on the edges that lie a whole number of prescale periods 2^(PRE+1) after the restarting edge, and expiry comes after limit+1 ticks. The bench records the edge of each restart and counts edges from it, which gives the expected count and flag as closed formulas. `irq` follows the flag with no extra delay, so it is checked in the same sample as the flag. The collision case times its write so that it lands exactly on a computed expiry edge.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int PIT_CNT_W  = 16;
  localparam int PIT_PRE_W  = 4;
  localparam int PIT_ADDR_W = 3;

  localparam logic [PIT_ADDR_W-1:0] OFS_CTRL = 3'd0;
  localparam logic [PIT_ADDR_W-1:0] OFS_MOD  = 3'd2;
  localparam logic [PIT_ADDR_W-1:0] OFS_CNT  = 3'd4;

  localparam int BIT_EN   = 0;
  localparam int BIT_RLD  = 1;
  localparam int BIT_FLAG = 2;
  localparam int BIT_IE   = 3;
  localparam int BIT_OVW  = 4;
  localparam int BIT_DBG  = 5;
  localparam int BIT_DOZE = 6;
  localparam int PRE_LSB  = 8;

  typedef struct packed {
    logic [PIT_PRE_W-1:0] pre;
    logic                 doze;
    logic                 dbg;
    logic                 ovw;
    logic                 ie;
    logic                 rld;
    logic                 en;
  } pit_cfg_t;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler
  import pit_pkg::*;
#(
  parameter int PRE_W = PIT_PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);
  localparam int PS_W = 2 ** PRE_W;

  logic [PS_W-1:0] ps_cnt;
  logic [PS_W:0]   span;
  logic [PRE_W:0]  shamt;
  logic [PS_W-1:0] mask;

  always_comb begin
    shamt = {1'b0, pre} + (PRE_W + 1)'(1);
    span  = ((PS_W + 1)'(1) << shamt) - (PS_W + 1)'(1);
    mask  = span[PS_W-1:0];
  end

  assign tick = run && ((ps_cnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ps_cnt <= '0;
    else if (restart) ps_cnt <= '0;
    else if (run)     ps_cnt <= ps_cnt + PS_W'(1);
  end

  // R3: after a restart, no tick until the phase has advanced
  a_r3_no_tick_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);
endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
#(
  parameter int CNT_W = PIT_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] restart_val,
  input  logic             ovw_load,
  input  logic [CNT_W-1:0] ovw_val,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  assign expire = tick && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (restart)  cnt <= restart_val;
    else if (ovw_load) cnt <= ovw_val;
    else if (expire)   cnt <= limit;
    else if (tick)     cnt <= cnt - CNT_W'(1);
  end

  a_r8_restart_loads: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt == $past(restart_val));
  a_r4_expire_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !restart && !ovw_load) |=> cnt == $past(limit));
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart && !ovw_load) |=> $stable(cnt));
  a_r9_ovw_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (ovw_load && !restart) |=> cnt == $past(ovw_val));
endmodule

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int CNT_W  = PIT_CNT_W,
  parameter int ADDR_W = PIT_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              expire,
  input  logic [CNT_W-1:0]  cnt,
  output pit_cfg_t          cfg,
  output logic              flag,
  output logic [CNT_W-1:0]  limit,
  output logic              restart,
  output logic [CNT_W-1:0]  restart_val,
  output logic              ovw_load,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq
);
  logic [CNT_W-1:0] modulus;
  pit_cfg_t         new_cfg;
  logic             wr_ctrl, wr_mod, clr_req;
  logic             unused_bits;

  assign unused_bits = ^{wdata[7], wdata[CNT_W-1:12]};

  always_comb begin
    new_cfg.en   = wdata[BIT_EN];
    new_cfg.rld  = wdata[BIT_RLD];
    new_cfg.ie   = wdata[BIT_IE];
    new_cfg.ovw  = wdata[BIT_OVW];
    new_cfg.dbg  = wdata[BIT_DBG];
    new_cfg.doze = wdata[BIT_DOZE];
    new_cfg.pre  = wdata[PRE_LSB +: PIT_PRE_W];
  end

  assign wr_ctrl = we && (addr == OFS_CTRL);
  assign wr_mod  = we && (addr == OFS_MOD);
  assign clr_req = (wr_ctrl && wdata[BIT_FLAG]) || wr_mod;

  // Only bits other than the interrupt enable decide a restart
  assign restart = wr_ctrl &&
    ({new_cfg.pre, new_cfg.doze, new_cfg.dbg, new_cfg.ovw, new_cfg.rld, new_cfg.en} !=
     {cfg.pre, cfg.doze, cfg.dbg, cfg.ovw, cfg.rld, cfg.en});
  assign restart_val = new_cfg.rld ? modulus : '1;
  assign ovw_load    = wr_mod && cfg.ovw;
  assign limit       = cfg.rld ? modulus : '1;
  assign irq         = flag && cfg.ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= '0;
      modulus <= '1;
      flag    <= 1'b0;
    end else begin
      if (wr_ctrl) cfg <= new_cfg;
      if (wr_mod)  modulus <= wdata;
      if (expire)       flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CTRL: begin
        rdata[BIT_EN]   = cfg.en;
        rdata[BIT_RLD]  = cfg.rld;
        rdata[BIT_FLAG] = flag;
        rdata[BIT_IE]   = cfg.ie;
        rdata[BIT_OVW]  = cfg.ovw;
        rdata[BIT_DBG]  = cfg.dbg;
        rdata[BIT_DOZE] = cfg.doze;
        rdata[PRE_LSB +: PIT_PRE_W] = cfg.pre;
      end
      OFS_MOD: rdata = modulus;
      OFS_CNT: rdata = cnt;
      default: rdata = '0;
    endcase
  end

  a_r10_expire_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);
  a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[BIT_FLAG] && !expire) |=> !flag);
  a_r6_flag_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!expire && !clr_req) |=> flag == $past(flag));
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int CNT_W  = PIT_CNT_W,
  parameter int ADDR_W = PIT_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  pit_cfg_t         cfg;
  logic             flag, restart, ovw_load, tick, expire;
  logic [CNT_W-1:0] limit, restart_val, cnt;

  pit_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .expire(expire), .cnt(cnt), .cfg(cfg), .flag(flag), .limit(limit),
    .restart(restart), .restart_val(restart_val), .ovw_load(ovw_load),
    .rdata(bus_rdata), .irq(irq)
  );

  pit_prescaler #(.PRE_W(PIT_PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(restart), .run(cfg.en),
    .pre(cfg.pre), .tick(tick)
  );

  pit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(restart), .restart_val(restart_val),
    .ovw_load(ovw_load), .ovw_val(bus_wdata), .tick(tick), .limit(limit),
    .cnt(cnt), .expire(expire)
  );

  // R5: an asserted interrupt always comes from a raised flag
  a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
endmodule

// File: tb/pit_timer_tb.sv
module pit_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int t0 = 0;
  bit done = 0;

  pit_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] exp_cnt(int lim, int n, int m);
    int k = m / n;
    return 16'(lim - (k % (lim + 1)));
  endfunction

  function automatic logic exp_flag(int lim, int n, int m);
    return (m / n) >= (lim + 1);
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wait_until(int m);
    while (cyc - t0 < m) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 16'h0000);
    rd(2, v); chk("R1 mod", v, 16'hFFFF);
    rd(4, v); chk("R1 cnt", v, 16'h0000);
    chk("R1 irq", {15'b0, irq}, 16'h0000);

    // R2 control layout, unused bits, flag bit not stored
    wr(0, 16'hFF76);
    rd(0, v); chk("R2 ctrl readback", v, 16'h0F72);
    wr(0, 16'h0004);

    // R3 free-running PRE=0
    wr(0, 16'h0001); t0 = cyc;
    wait_until(10);
    rd(4, v); chk("R3 free run rate", v, exp_cnt(65535, 2, 10));

    // R9 modulus write without overwrite leaves count
    wr(0, 16'h0004);
    rd(4, v); chk("R8 restart to 0xFFFF", v, 16'hFFFF);
    wr(2, 16'd5);
    rd(4, v); chk("R9 no overwrite", v, 16'hFFFF);

    // R4 reload mode, PRE=1, limit 5: period 24 edges
    wr(0, 16'h0103); t0 = cyc;
    wait_until(23);
    rd(4, v); chk("R4 count before expiry", v, exp_cnt(5, 4, 23));
    rd(0, v); chk("R4 flag before expiry", {15'b0, v[2]}, 16'h0000);
    wait_until(24);
    rd(4, v); chk("R4 reload on expiry", v, 16'd5);
    rd(0, v); chk("R4 flag on expiry", {15'b0, v[2]}, 16'h0001);
    chk("R5 irq masked", {15'b0, irq}, 16'h0000);

    // R7 IE-only write, R6 flag kept with bit2=0
    wr(0, 16'h010B);
    chk("R5 irq enabled", {15'b0, irq}, 16'h0001);
    rd(4, v); chk("R7 no restart on ie write", v, exp_cnt(5, 4, cyc - t0));
    wait_until(30);
    wr(0, 16'h010F);
    chk("R6 w1c irq", {15'b0, irq}, 16'h0000);
    rd(0, v); chk("R6 w1c ctrl", v, 16'h010B);
    rd(4, v); chk("R7 no restart on w1c", v, exp_cnt(5, 4, cyc - t0));

    // R2 write to count ignored
    wr(4, 16'h0003);
    rd(4, v); chk("R2 cnt write ignored", v, exp_cnt(5, 4, cyc - t0));
    rd(0, v); chk("R2 ctrl unchanged", v, 16'h010B);

    // R10 clear on the expiry edge
    wait_until(47);
    wr(0, 16'h010F);
    chk("R10 expiry beats clear", {15'b0, irq}, 16'h0001);

    // R9 modulus write clears flag, no overwrite in reload mode
    wr(2, 16'd9);
    chk("R9 mod write clears flag", {15'b0, irq}, 16'h0000);
    rd(4, v); chk("R9 reload no overwrite", v, 16'd5);
    wait_until(72);
    rd(4, v); chk("R9 new limit used", v, 16'd9);
    rd(0, v); chk("R4 flag after new limit", {15'b0, v[2]}, 16'h0001);

    // R9 overwrite in reload mode
    wr(0, 16'h011F); t0 = cyc;
    rd(4, v); chk("R8 restart to modulus", v, 16'd9);
    wr(2, 16'h0040);
    rd(4, v); chk("R9 overwrite reload", v, 16'h0040);

    // R9 overwrite in free-run mode
    wr(0, 16'h0015);
    rd(4, v); chk("R8 free run limit", v, 16'hFFFF);
    wr(2, 16'h1234);
    rd(4, v); chk("R9 overwrite free run", v, 16'h1234);

    // R8 disabled restart holds
    wr(0, 16'h0302);
    rd(4, v); chk("R8 restart disabled", v, 16'h1234);
    repeat (50) @(negedge clk);
    rd(4, v); chk("R8 hold disabled", v, 16'h1234);

    // R4 modulus 0 expires on every tick
    wr(2, 16'h0000);
    wr(0, 16'h000B); t0 = cyc;
    wait_until(1);
    chk("R4 mod0 no flag yet", {15'b0, irq}, 16'h0000);
    wait_until(2);
    chk("R4 mod0 flag", {15'b0, irq}, 16'h0001);
    rd(4, v); chk("R4 mod0 count", v, 16'h0000);

    // random configurations
    for (int i = 0; i < 20; i++) begin
      int rld = $urandom % 2;
      int pre = $urandom % 3;
      int md  = $urandom % 31;
      int ie  = $urandom % 2;
      int m   = $urandom % 250;
      int lim, n;
      logic ef;
      wr(0, 16'h0004);
      wr(2, 16'(md));
      wr(0, 16'((pre << 8) | (ie << 3) | (rld << 1) | 1)); t0 = cyc;
      wait_until(m);
      lim = (rld != 0) ? md : 65535;
      n = 2 << pre;
      ef = exp_flag(lim, n, cyc - t0);
      rd(4, v); chk("R3 R4 random count", v, exp_cnt(lim, n, cyc - t0));
      rd(0, v); chk("R4 random flag", {15'b0, v[2]}, {15'b0, ef});
      chk("R5 random irq", {15'b0, irq}, {15'b0, ef & (ie != 0)});
    end

    finish_run();
  end
endmodule